// File: doc/BRIEF.md
# Parity-Checked LSB-First SPI Master Shift Engine

This block is the data path of a master-mode SPI port. A single strobe starts one frame: the transmit word is taken in, the serial clock runs for a fixed number of cycles set by the frame length, and the receive word is loaded when the frame ends. The frame length is a parameter between 8 and 32 bits inside a wider data word. Bits travel least significant first in both directions.

When parity is on, the top bit of the frame is not sent from the transmit word. The engine sends a computed parity bit in its place, covering every lower frame bit. On the receive side, the full received frame, including its parity bit, is checked against the chosen parity sense. A mismatch sets an error flag.

Any word bits above the frame are never shifted. They go straight from the transmit word to the receive word. This lets software tag a frame, or clear those bits by writing zeros. The serial link uses mode 0: the clock idles low, output data changes on falling edges, and input data is sampled on rising edges.

Top module: `spi_par_engine`

## Requirements
- R1: After reset, `sclk`, `mosi`, `busy`, `done`, `par_err` and all of `rx_word` are 0.
- R2: A `start` pulse seen while `busy` is 0 takes in `tx_word`, `par_en` and `par_odd` and raises `busy`. A `start` seen while `busy` is 1 is ignored: the serial outputs and the final `rx_word` of the running frame are those of the first request.
- R3: `sclk` is low whenever the engine is idle. During a frame it gives exactly FRAME_LEN high pulses. Each level lasts HALF_DIV system clocks, and the first rising edge comes HALF_DIV clocks after the start edge.
- R4: Frame bit k (k = 0 first, up to FRAME_LEN-1) sits on `mosi` from the k-th falling edge of `sclk` to the next one. Bit 0 is on `mosi` from the start edge. `mosi` never changes at a rising edge.
- R5: The value of `miso` sampled at the k-th rising edge of `sclk` (k from 0) lands in bit k of `rx_word`.
- R6: With `par_en`=1, frame bit FRAME_LEN-1 is sent as the XOR of `tx_word` bits FRAME_LEN-2..0, inverted when `par_odd`=1. So the sent frame has an even count of ones for `par_odd`=0 and an odd count for `par_odd`=1.
- R7: With `par_en`=0, the frame bits of `tx_word` go out unchanged and `par_err` stays 0 whatever `miso` carries.
- R8: Bits DATA_W-1..FRAME_LEN of `rx_word` equal those bits of `tx_word` as taken at start.
- R9: With parity on, `par_err` is set when a frame's received bits FRAME_LEN-1..0 have a count of ones whose sense differs from `par_odd`. It returns to 0 at the next accepted start.
- R10: `rx_word` and `par_err` are updated at the last falling edge of `sclk`. `done` is high for exactly one system clock, the next one, and `busy` falls with it. A frame therefore lasts 2*HALF_DIV*FRAME_LEN+1 clocks of `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one frame (used only when idle) |
| tx_word | input | DATA_W | Word to send; upper field passes through |
| par_en | input | 1 | Insert and check the parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| rx_word | output | DATA_W | Last received word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after rx_word is updated |
| par_err | output | 1 | Parity mismatch on the last frame |

## Verification
A wrong bit counter or divider phase shows on `sclk` within one half period, because the bench predicts the level of `sclk` on every clock. An output register that is out of order or stale shows on `mosi` at the falling edge where the wrong bit first appears. Errors in the receive path, the parity sense or the upper-field pass-through show only at the end of the frame. At that point `rx_word`, `par_err` and the one-cycle `done` are compared with values the bench built from the bits it fed in.

// File: rtl/spi_par_pkg.sv
// Shared types for the SPI parity shift engine.
package spi_par_pkg;

    // Transfer sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } xfer_state_t;

    // Parity options frozen for the length of one frame.
    typedef struct packed {
        logic enable;
        logic odd;
    } par_cfg_t;

endpackage

// File: rtl/spi_par_clkgen.sv
// Serial clock generator.
// Makes a mode-0 serial clock (idle low) by toggling every HALF_DIV system
// clocks while run is high. rise/fall mark the cycle whose closing edge makes
// sclk go high/low. Assumes run drops only at or after a falling tick.
module spi_par_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));
    assign rise = tick && !sclk;
    assign fall = tick && sclk;

    // Count half periods and toggle the serial clock at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);                                        // R3
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));                                       // R3

endmodule

// File: rtl/spi_par_parity.sv
// Parity generator and checker.
// gen_bit completes the transmit frame so that its ones count matches the
// requested sense; rx_bad flags a received frame whose sense differs.
// Purely combinational; FRAME_LEN must be at least 2.
module spi_par_parity #(
    parameter int FRAME_LEN = 24
) (
    input  logic [FRAME_LEN-2:0] tx_data,
    input  logic                 tx_odd,
    input  logic [FRAME_LEN-1:0] rx_frame,
    input  logic                 rx_odd,
    output logic                 gen_bit,
    output logic                 rx_bad
);
    // Even sense: XOR of all ones is 0; odd sense: it is 1.
    always_comb begin
        gen_bit = (^tx_data) ^ tx_odd;
        rx_bad  = (^rx_frame) ^ rx_odd;
    end

endmodule

// File: rtl/spi_par_shifter.sv
// Bidirectional LSB-first shift register.
// The low FRAME_LEN bits shift right one place per rise, taking miso in at the
// top of the frame; the bits above the frame are held. mosi is a separate
// register refreshed from bit 0 on load and on each requested falling edge.
module spi_par_shifter #(
    parameter int DATA_W    = 32,
    parameter int FRAME_LEN = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              shift,
    input  logic              miso,
    input  logic              upd_out,
    output logic              mosi,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] sreg;
    logic [DATA_W-1:0] shifted;

    // Build the next shift value; the pass-through field exists only for short frames.
    generate
        if (FRAME_LEN == DATA_W) begin : g_full
            assign shifted = {miso, sreg[DATA_W-1:1]};
        end else begin : g_short
            assign shifted = {sreg[DATA_W-1:FRAME_LEN], miso, sreg[FRAME_LEN-1:1]};

            AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                !load |=> $stable(sreg[DATA_W-1:FRAME_LEN]));  // R8
        end
    endgenerate

    // Load, shift and refresh the serial output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            mosi <= 1'b0;
        end else if (load) begin
            sreg <= load_word;
            mosi <= load_word[0];
        end else begin
            if (shift) begin
                sreg <= shifted;
            end
            if (upd_out) begin
                mosi <= sreg[0];
            end
        end
    end

    assign word = sreg;

endmodule

// File: rtl/spi_par_engine.sv
// SPI master shift engine with parity (top).
// Runs one LSB-first frame of FRAME_LEN bits per accepted start. It inserts
// the parity bit on the way out, checks parity on the way in, and passes the
// bits above the frame through. Assumes 8 <= FRAME_LEN <= DATA_W and HALF_DIV >= 1.
module spi_par_engine #(
    parameter int DATA_W    = 32,
    parameter int FRAME_LEN = 24,
    parameter int HALF_DIV  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              done,
    output logic              par_err
);
    import spi_par_pkg::*;

    localparam int BW = $clog2(FRAME_LEN + 1);

    xfer_state_t       state;
    par_cfg_t          cfg;
    logic [BW-1:0]     bit_cnt;
    logic [DATA_W-1:0] load_word;
    logic [DATA_W-1:0] sh_word;
    logic              accept;
    logic              rise;
    logic              fall;
    logic              last_fall;
    logic              gen_bit;
    logic              rx_bad;

    assign accept    = start && (state == ST_IDLE);
    assign last_fall = fall && (bit_cnt == BW'(FRAME_LEN));
    assign busy      = (state != ST_IDLE);

    // Put the parity bit in place of the top frame bit when enabled.
    always_comb begin
        load_word = tx_word;
        if (par_en) begin
            load_word[FRAME_LEN-1] = gen_bit;
        end
    end

    spi_par_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == ST_RUN),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    spi_par_parity #(.FRAME_LEN(FRAME_LEN)) u_par (
        .tx_data (tx_word[FRAME_LEN-2:0]),
        .tx_odd  (par_odd),
        .rx_frame(sh_word[FRAME_LEN-1:0]),
        .rx_odd  (cfg.odd),
        .gen_bit (gen_bit),
        .rx_bad  (rx_bad)
    );

    spi_par_shifter #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_word(load_word),
        .shift    (rise),
        .miso     (miso),
        .upd_out  (fall && !last_fall),
        .mosi     (mosi),
        .word     (sh_word)
    );

    // Sequence a frame: accept, count bits, copy the result, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cfg     <= '0;
            bit_cnt <= '0;
            rx_word <= '0;
            par_err <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_RUN;
                        cfg.enable <= par_en;
                        cfg.odd    <= par_odd;
                        bit_cnt    <= '0;
                        par_err    <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (last_fall) begin
                        rx_word <= sh_word;
                        par_err <= cfg.enable && rx_bad;
                        state   <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                        // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                        // R10
    AST_RX_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word != $past(rx_word)) |-> busy);                  // R10
    AST_MOSI_STILL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> $stable(mosi));                                // R4
    AST_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BW'(FRAME_LEN));                             // R3
    AST_ERR_NEEDS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && busy) |-> cfg.enable);                      // R7

endmodule

// File: tb/spi_par_engine_test.sv
`timescale 1ns/1ps
module spi_par_engine_test;
    localparam int DW  = 32;
    localparam int F   = 24;
    localparam int H   = 2;
    localparam int TOT = 2 * H * F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] tx_word = '0;
    logic          par_en = 1'b0;
    logic          par_odd = 1'b0;
    logic          miso = 1'b0;
    logic          sclk, mosi, busy, done, par_err;
    logic [DW-1:0] rx_word;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    spi_par_engine #(.DATA_W(DW), .FRAME_LEN(F), .HALF_DIV(H)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .par_en(par_en), .par_odd(par_odd), .miso(miso), .sclk(sclk),
        .mosi(mosi), .rx_word(rx_word), .busy(busy), .done(done),
        .par_err(par_err)
    );

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Miso pattern whose frame parity matches (good=1) or misses the sense.
    function automatic logic [F-1:0] make_pat(input logic [F-2:0] d, input logic odd, input logic good);
        return {(^d) ^ odd ^ ~good, d};
    endfunction

    // One frame driven and predicted cycle by cycle; n counts edges from the start edge.
    task automatic run_xfer(input logic [DW-1:0] tx, input logic en, input logic odd,
                            input logic [F-1:0] pat, input bit inject);
        logic [DW-1:0] frame;
        logic          exp_err;
        frame = tx;
        if (en) frame[F-1] = (^tx[F-2:0]) ^ odd;                   // R6
        exp_err = en && (((^pat) ^ odd) == 1'b1);                  // R9
        tx_word = tx; par_en = en; par_odd = odd; start = 1'b1; miso = pat[0];
        for (int n = 0; n <= TOT + 2; n++) begin
            @(posedge clk); #1;
            check("R2", "busy", {31'd0, busy}, {31'd0, (n <= TOT)});
            check("R10", "done", {31'd0, done}, {31'd0, (n == TOT + 1)});
            check("R3", "sclk", {31'd0, sclk},
                  {31'd0, (n >= 1 && n < TOT) ? (((n / H) % 2) == 1) : 1'b0});
            check("R4", "mosi", {31'd0, mosi},
                  {31'd0, (n < TOT) ? frame[n / (2 * H)] : frame[F-1]});
            if (n < TOT) begin
                check("R9", "par_err cleared", {31'd0, par_err}, 32'd0);
            end else begin
                check("R5", "rx frame", {8'd0, rx_word[F-1:0]}, {8'd0, pat});
                check("R8", "rx upper", {24'd0, rx_word[DW-1:F]}, {24'd0, tx[DW-1:F]});
                check(en ? "R9" : "R7", "par_err", {31'd0, par_err}, {31'd0, exp_err});
            end
            start = 1'b0;
            tx_word = ~tx;
            par_en = ~en;
            par_odd = ~odd;
            if (inject && (n == 10 || n == TOT - 3)) start = 1'b1;  // R2: ignored
            miso = pat[(n / (2 * H) < F) ? n / (2 * H) : F - 1];
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1", "sclk", {31'd0, sclk}, 32'd0);
        check("R1", "mosi", {31'd0, mosi}, 32'd0);
        check("R1", "busy", {31'd0, busy}, 32'd0);
        check("R1", "done", {31'd0, done}, 32'd0);
        check("R1", "par_err", {31'd0, par_err}, 32'd0);
        check("R1", "rx_word", rx_word, 32'd0);
        @(posedge clk); #1;
        // Even parity, clean receive.
        run_xfer(32'hA5_3C96E1, 1'b1, 1'b0, make_pat(23'h5A1F3, 1'b0, 1'b1), 1'b0);
        // Odd parity, corrupted receive sets the error.
        run_xfer(32'h7E_00FF0F, 1'b1, 1'b1, make_pat(23'h12345, 1'b1, 1'b0), 1'b0);
        // Next start clears it; odd parity, clean receive.
        run_xfer(32'h00_F0F0F1, 1'b1, 1'b1, make_pat(23'h7FFFFF, 1'b1, 1'b1), 1'b0);
        // Parity off: top frame bit sent raw, bad-looking miso raises nothing.
        run_xfer(32'hC3_800001, 1'b0, 1'b0, make_pat(23'h00001, 1'b0, 1'b0), 1'b0);
        // Starts during the frame are ignored.
        run_xfer(32'h5A_ABCDEF, 1'b1, 1'b0, make_pat(23'h2AAAAA, 1'b0, 1'b0), 1'b1);
        // All-zero word and all-ones miso with odd parity.
        run_xfer(32'h00_000000, 1'b1, 1'b1, 24'hFFFFFF, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule